// File: doc/BRIEF.md
# Synchronized Dimming PWM Generator

This block produces a backlight dimming pulse train whose cycle length comes from one of two places. As the timing source (master role), it counts a programmed number of ticks of a slow fixed timebase per cycle and drives a cycle-rate square wave onto a shared sync line. Several other instances can be placed in the follower role (slave) on that line. Each follower measures the incoming cycle length in timebase ticks, keeps a running estimate of it, and restarts its own PWM cycle on every rising edge of the sync line.

The high time of each cycle comes from a duty register, counted in timebase ticks from the start of the cycle. The internal pulse is ANDed with an external PWM pin, so either source can be held fully on while the other one dims. While the follower's tracking loop is out of lock, the output is held low. Period and duty writes are single-cycle strobes. They take effect only at the next cycle boundary.

Top module: `pwm_sync_gen`

## Requirements
- R1: With `master_mode` high, one PWM cycle lasts `period` timebase ticks (each tick is TICK_DIV clocks). `sync_out` rises once at the start of every cycle and is high for the first `period/2` ticks. `sync_oe` is high.
- R2: A period value of 0 or 1 is treated as 2 ticks.
- R3: Within a cycle, `pwm_out` is high for the first `duty` ticks. A duty of 0 gives a constant low output. A duty greater than or equal to the cycle period gives a constant high output.
- R4: A period or duty write made during a cycle does not change that cycle; the new value governs from the next cycle start.
- R5: `pwm_out` is the AND of the internal pulse and `ext_pwm`. `ext_pwm` passes through a two-stage synchronizer, so a low level sampled on one clock edge forces `pwm_out` low three edges later.
- R6: In the master role, `locked` rises at the first cycle start after reset or after entering the role, and then it stays high as long as the role is kept. `pwm_out` stays low until then.
- R7: With `master_mode` low, `sync_oe` and `sync_out` are low. Each rising edge on `sync_in` restarts the PWM cycle, and the restart lands three clock edges after the edge is sampled.
- R8: In the follower role, the first sync edge only arms the measurement. The next edge loads the estimate. `locked` rises after LOCK_N further consecutive measured periods (4 by default) fall within tolerance of the estimate. Leaving or entering a role clears lock.
- R9: The tolerance is the estimate shifted right by TOL_SHIFT. A period within it updates the estimate and keeps lock. A single out-of-tolerance period while locked does not drop lock and leaves the estimate unchanged.
- R10: UNLOCK_N consecutive out-of-tolerance periods (2 by default) clear `locked` and reload the estimate from the last measurement. Whenever `locked` is low, `pwm_out` is low on the following clock.
- R11: While `rst` is high, `pwm_out`, `sync_out`, `sync_oe` and `locked` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| master_mode | input | 1 | 1 = generate the period and drive the sync line, 0 = follow the sync line |
| per_wr | input | 1 | Write strobe for the period register |
| per_data | input | PER_W | Period in timebase ticks |
| duty_wr | input | 1 | Write strobe for the duty register |
| duty_data | input | PER_W | High time in timebase ticks |
| ext_pwm | input | 1 | External dimming input, ANDed into the output |
| sync_in | input | 1 | Sync line as seen at the pin (follower role) |
| sync_out | output | 1 | Cycle-rate square wave (master role) |
| sync_oe | output | 1 | Output enable for the sync line |
| pwm_out | output | 1 | Dimming output |
| locked | output | 1 | Period source is locked |

## Verification
In the master role, `sync_out` and `pwm_out` are registered from the same cycle counter. Both move one clock after a cycle start, so the bench aligns every high-time and length count to a sampled rising edge of `sync_out` and reaches exact clock counts. A register write is checked over two cycles: the cycle in which the write happens, and the one after it. Random writes skip one whole cycle before they are measured. In the follower role, the cycle restarts and lock changes three edges after a sync edge. Each sync period is driven as a window of fixed length, and lock is checked at the end of the window, well after that latency. The high time in the follower role depends on the tick phase, so it is compared within one tick. The external gate is checked over a whole cycle, well past its three-edge latency.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;

  // tracking-loop state of the follower role (also used to hold master lock)
  typedef enum logic [1:0] {
    TRK_IDLE   = 2'd0,
    TRK_ARMED  = 2'd1,
    TRK_ACQ    = 2'd2,
    TRK_LOCKED = 2'd3
  } trk_state_t;

endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int TICK_DIV = 3704
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int DIV_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      tick  <= 1'b0;
    end else begin
      div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
      tick  <= (div_q == DIV_LAST);
    end
  end
endmodule

// File: rtl/pwm_sync_in.sv
module pwm_sync_in #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/pwm_period_track.sv
module pwm_period_track
  import pwm_sync_pkg::*;
#(
  parameter int PER_W     = 18,
  parameter int LOCK_N    = 4,
  parameter int UNLOCK_N  = 2,
  parameter int TOL_SHIFT = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             master,
  input  logic             tick,
  input  logic             sync_lvl,
  input  logic             mstart,
  output logic             slave_start,
  output logic [PER_W-1:0] est,
  output logic             locked
);
  localparam int CNT_W = $clog2(LOCK_N + UNLOCK_N + 1);
  localparam logic [CNT_W-1:0] GOOD_LAST = CNT_W'(LOCK_N - 1);
  localparam logic [CNT_W-1:0] BAD_LAST  = CNT_W'(UNLOCK_N - 1);

  trk_state_t       st_q;
  logic             mode_q;
  logic             lvl_q;
  logic [PER_W-1:0] tcnt_q;
  logic [CNT_W-1:0] good_q, bad_q;

  logic             edge_det;
  logic [PER_W:0]   meas_w;
  logic [PER_W-1:0] meas, diff, tol;
  logic             in_tol;

  assign edge_det    = sync_lvl & ~lvl_q;
  assign slave_start = edge_det & ~master & (mode_q == master);

  // ticks in the window (previous edge, this edge]
  assign meas_w = {1'b0, tcnt_q} + {{PER_W{1'b0}}, tick};
  assign meas   = meas_w[PER_W] ? '1 : meas_w[PER_W-1:0];
  assign diff   = (meas >= est) ? (meas - est) : (est - meas);
  assign tol    = est >> TOL_SHIFT;
  assign in_tol = (diff <= tol);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= TRK_IDLE;
      mode_q <= 1'b0;
      lvl_q  <= 1'b0;
      tcnt_q <= '0;
      est    <= '0;
      good_q <= '0;
      bad_q  <= '0;
    end else begin
      mode_q <= master;
      lvl_q  <= sync_lvl;
      if (master != mode_q) begin
        st_q   <= TRK_IDLE;
        tcnt_q <= '0;
        good_q <= '0;
        bad_q  <= '0;
      end else if (master) begin
        if (mstart) st_q <= TRK_LOCKED;
      end else if (edge_det) begin
        tcnt_q <= '0;
        unique case (st_q)
          TRK_IDLE:  st_q <= TRK_ARMED;
          TRK_ARMED: begin
            est    <= meas;
            good_q <= '0;
            st_q   <= TRK_ACQ;
          end
          TRK_ACQ: begin
            est <= meas;
            if (!in_tol) begin
              good_q <= '0;
            end else if (good_q == GOOD_LAST) begin
              good_q <= '0;
              bad_q  <= '0;
              st_q   <= TRK_LOCKED;
            end else begin
              good_q <= good_q + 1'b1;
            end
          end
          TRK_LOCKED: begin
            if (in_tol) begin
              est   <= meas;
              bad_q <= '0;
            end else if (bad_q == BAD_LAST) begin
              est    <= meas;
              bad_q  <= '0;
              good_q <= '0;
              st_q   <= TRK_ACQ;
            end else begin
              bad_q <= bad_q + 1'b1;
            end
          end
          default: st_q <= TRK_IDLE;
        endcase
      end else if (tick && (tcnt_q != '1)) begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end
  end

  assign locked = (st_q == TRK_LOCKED);
endmodule

// File: rtl/pwm_cycle_core.sv
module pwm_cycle_core #(
  parameter int              PER_W    = 18,
  parameter logic [PER_W-1:0] DEF_PER  = PER_W'(250),
  parameter logic [PER_W-1:0] DEF_DUTY = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             master,
  input  logic             tick,
  input  logic             slave_start,
  input  logic [PER_W-1:0] slave_per,
  input  logic             per_wr,
  input  logic [PER_W-1:0] per_data,
  input  logic             duty_wr,
  input  logic [PER_W-1:0] duty_data,
  input  logic             ext_lvl,
  input  logic             locked,
  output logic             mstart,
  output logic             pwm_out,
  output logic             sync_out,
  output logic             sync_oe
);
  localparam logic [PER_W-1:0] MIN_PER = PER_W'(2);

  logic [PER_W-1:0] per_sh, duty_sh;
  logic [PER_W-1:0] per_act, duty_act, cnt_q;
  logic [PER_W-1:0] per_next;
  logic             start;
  logic             pulse;

  function automatic logic [PER_W-1:0] clamp_per(input logic [PER_W-1:0] p);
    return (p < MIN_PER) ? MIN_PER : p;
  endfunction

  // shadow registers, written at any time
  always_ff @(posedge clk) begin
    if (rst) begin
      per_sh  <= DEF_PER;
      duty_sh <= DEF_DUTY;
    end else begin
      if (per_wr)  per_sh  <= per_data;
      if (duty_wr) duty_sh <= duty_data;
    end
  end

  assign mstart   = master & tick & (cnt_q >= per_act - 1'b1);
  assign start    = mstart | slave_start;
  assign per_next = clamp_per(master ? per_sh : slave_per);

  // cycle counter; active values are latched only at a cycle start
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      per_act  <= clamp_per(DEF_PER);
      duty_act <= DEF_DUTY;
    end else if (start) begin
      cnt_q    <= '0;
      per_act  <= per_next;
      duty_act <= duty_sh;
    end else if (tick && (cnt_q != '1)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pulse = (duty_act >= per_act) | (cnt_q < duty_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_out  <= 1'b0;
      sync_out <= 1'b0;
      sync_oe  <= 1'b0;
    end else begin
      pwm_out  <= locked & ext_lvl & pulse;
      sync_out <= master & (cnt_q < (per_act >> 1));
      sync_oe  <= master;
    end
  end
endmodule

// File: rtl/pwm_sync_gen.sv
module pwm_sync_gen #(
  parameter int               PER_W     = 18,
  parameter int               TICK_DIV  = 3704,
  parameter int               SYNC_STG  = 2,
  parameter int               LOCK_N    = 4,
  parameter int               UNLOCK_N  = 2,
  parameter int               TOL_SHIFT = 10,
  parameter logic [PER_W-1:0] DEF_PER   = PER_W'(250),
  parameter logic [PER_W-1:0] DEF_DUTY  = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             master_mode,
  input  logic             per_wr,
  input  logic [PER_W-1:0] per_data,
  input  logic             duty_wr,
  input  logic [PER_W-1:0] duty_data,
  input  logic             ext_pwm,
  input  logic             sync_in,
  output logic             sync_out,
  output logic             sync_oe,
  output logic             pwm_out,
  output logic             locked
);
  logic             tick;
  logic             ext_lvl, sync_lvl;
  logic             mstart, slave_start;
  logic [PER_W-1:0] est;

  pwm_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  pwm_sync_in #(.STAGES(SYNC_STG)) u_ext_sync (
    .clk(clk), .rst(rst), .din(ext_pwm), .dout(ext_lvl)
  );

  pwm_sync_in #(.STAGES(SYNC_STG)) u_line_sync (
    .clk(clk), .rst(rst), .din(sync_in), .dout(sync_lvl)
  );

  pwm_period_track #(
    .PER_W(PER_W), .LOCK_N(LOCK_N), .UNLOCK_N(UNLOCK_N), .TOL_SHIFT(TOL_SHIFT)
  ) u_track (
    .clk(clk), .rst(rst), .master(master_mode), .tick(tick),
    .sync_lvl(sync_lvl), .mstart(mstart), .slave_start(slave_start),
    .est(est), .locked(locked)
  );

  pwm_cycle_core #(
    .PER_W(PER_W), .DEF_PER(DEF_PER), .DEF_DUTY(DEF_DUTY)
  ) u_core (
    .clk(clk), .rst(rst), .master(master_mode), .tick(tick),
    .slave_start(slave_start), .slave_per(est),
    .per_wr(per_wr), .per_data(per_data),
    .duty_wr(duty_wr), .duty_data(duty_data),
    .ext_lvl(ext_lvl), .locked(locked), .mstart(mstart),
    .pwm_out(pwm_out), .sync_out(sync_out), .sync_oe(sync_oe)
  );
endmodule

// File: rtl/pwm_sync_gen_chk.sv
module pwm_sync_gen_chk (
  input logic clk,
  input logic rst,
  input logic master_mode,
  input logic ext_pwm,
  input logic pwm_out,
  input logic sync_out,
  input logic sync_oe,
  input logic locked
);
  p_blank_unlocked_r10: assert property (@(posedge clk) disable iff (rst)
    !locked |=> !pwm_out);

  p_ext_gate_r5: assert property (@(posedge clk) disable iff (rst)
    !ext_pwm |-> ##3 !pwm_out);

  p_master_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (master_mode && $past(master_mode) && locked) |=> (!master_mode || locked));

  p_oe_follow_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sync_oe == $past(master_mode)));

  p_slave_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !sync_oe |-> !sync_out);

  always @(posedge clk) begin
    if (rst) begin
      a_reset_low_r11: assert (!locked);
    end
  end
endmodule

bind pwm_sync_gen pwm_sync_gen_chk u_chk (
  .clk(clk), .rst(rst), .master_mode(master_mode), .ext_pwm(ext_pwm),
  .pwm_out(pwm_out), .sync_out(sync_out), .sync_oe(sync_oe), .locked(locked)
);

// File: tb/tb_pwm_sync_gen.sv
`timescale 1ns/1ps
module tb_pwm_sync_gen;
  localparam int PER_W = 18;
  localparam int D     = 4;
  localparam int TOLS  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic master_mode = 1'b1;
  logic per_wr = 1'b0, duty_wr = 1'b0;
  logic [PER_W-1:0] per_data = '0, duty_data = '0;
  logic ext_pwm = 1'b1;
  logic sync_in = 1'b0;
  logic sync_out, sync_oe, pwm_out, locked;

  int checks = 0;
  int errors = 0;
  int wd = 0;

  always #5 clk = ~clk;

  pwm_sync_gen #(
    .PER_W(PER_W), .TICK_DIV(D), .TOL_SHIFT(TOLS), .DEF_PER(PER_W'(50))
  ) dut (
    .clk(clk), .rst(rst), .master_mode(master_mode),
    .per_wr(per_wr), .per_data(per_data),
    .duty_wr(duty_wr), .duty_data(duty_data),
    .ext_pwm(ext_pwm), .sync_in(sync_in),
    .sync_out(sync_out), .sync_oe(sync_oe), .pwm_out(pwm_out), .locked(locked)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(input int p);
    return ((p < 2) ? 2 : p) * D;
  endfunction

  function automatic int exp_hi(input int p, input int d);
    int pc = (p < 2) ? 2 : p;
    return (d >= pc) ? pc * D : d * D;
  endfunction

  task automatic wr_regs(input int p, input int d);
    per_wr = 1'b1; per_data = PER_W'(p);
    duty_wr = 1'b1; duty_data = PER_W'(d);
    @(negedge clk);
    per_wr = 1'b0; duty_wr = 1'b0;
  endtask

  task automatic wait_rise();
    logic p;
    p = sync_out;
    forever begin
      @(negedge clk);
      if (!p && sync_out) break;
      p = sync_out;
    end
  endtask

  // assumes the current negedge is a sync_out rise; ends on the next rise
  task automatic measure(input bit do_wr, input int p, input int d,
                         output int hi, output int len);
    logic prev;
    hi = int'(pwm_out); len = 1; prev = sync_out;
    if (do_wr) begin
      per_wr = 1'b1; per_data = PER_W'(p);
      duty_wr = 1'b1; duty_data = PER_W'(d);
    end
    forever begin
      @(negedge clk);
      per_wr = 1'b0; duty_wr = 1'b0;
      if (sync_out && !prev) break;
      prev = sync_out;
      hi += int'(pwm_out);
      len++;
    end
  endtask

  task automatic send_sync(input int ticks, output int hi);
    hi = 0;
    sync_in = 1'b1;
    for (int i = 0; i < ticks * D; i++) begin
      if (i == (ticks * D) / 2) sync_in = 1'b0;
      @(negedge clk);
      hi += int'(pwm_out);
    end
  endtask

  task automatic master_cycle(input int p, input int d, input string req);
    int hi, len;
    wr_regs(p, d);
    wait_rise();
    measure(1'b0, 0, 0, hi, len);
    measure(1'b0, 0, 0, hi, len);
    check(len == exp_len(p), {req, " length"}, len, exp_len(p));
    check(hi == exp_hi(p, d), {req, " high"}, hi, exp_hi(p, d));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", wd, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int hi, len, p, d;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    // R11 reset state
    check(!pwm_out && !sync_out && !sync_oe && !locked, "R11 reset outputs",
          {pwm_out, sync_out, sync_oe, locked}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!locked, "R6 unlocked before first start", locked, 0);
    wait_rise();
    check(locked, "R6 lock at first start", locked, 1);
    check(sync_oe, "R1 sync_oe in master", sync_oe, 1);
    measure(1'b0, 0, 0, hi, len);
    check(len == 50 * D, "R1 default length", len, 50 * D);
    check(hi == 0, "R3 default duty zero", hi, 0);

    master_cycle(20, 5, "R1");

    // R4: write in flight, then observe the next cycle
    wait_rise();
    measure(1'b1, 30, 15, hi, len);
    check(len == 80, "R4 old period kept", len, 80);
    check(hi == 20, "R4 old duty kept", hi, 20);
    measure(1'b0, 0, 0, hi, len);
    check(len == 120, "R4 new period", len, 120);
    check(hi == 60, "R4 new duty", hi, 60);

    master_cycle(1, 1, "R2 period one");
    master_cycle(0, 5, "R2 period zero");
    master_cycle(20, 0, "R3 duty zero");
    master_cycle(20, 20, "R3 duty equal");
    master_cycle(20, 25, "R3 duty above");

    for (int k = 0; k < 12; k++) begin
      p = $urandom_range(2, 60);
      d = $urandom_range(0, 70);
      master_cycle(p, d, "R1 R3 random");
    end

    // R5 external gate
    wr_regs(20, 10);
    ext_pwm = 1'b0;
    wait_rise();
    measure(1'b0, 0, 0, hi, len);
    measure(1'b0, 0, 0, hi, len);
    check(hi == 0, "R5 ext low gates", hi, 0);
    ext_pwm = 1'b1;
    measure(1'b0, 0, 0, hi, len);
    measure(1'b0, 0, 0, hi, len);
    check(hi == 40, "R5 ext high passes", hi, 40);
    check(locked, "R6 lock held in master", locked, 1);

    // follower role
    master_mode = 1'b0;
    wr_regs(40, 10);
    repeat (4) @(negedge clk);
    check(!sync_oe && !sync_out, "R7 sync line released", {sync_oe, sync_out}, 0);
    check(!locked, "R8 role change clears lock", locked, 0);
    repeat (5) send_sync(40, hi);
    check(!locked, "R8 not yet locked", locked, 0);
    send_sync(40, hi);
    check(locked, "R8 locked", locked, 1);
    wr_regs(40, 100);
    repeat (3) send_sync(40, hi);
    check(hi == 160, "R3 R7 follower full duty", hi, 160);
    wr_regs(40, 10);
    repeat (2) send_sync(40, hi);
    check(hi >= 36 && hi <= 44, "R7 follower duty", hi, 40);

    // R9 within tolerance and single outlier
    send_sync(43, hi);
    send_sync(40, hi);
    check(locked, "R9 small deviation keeps lock", locked, 1);
    send_sync(60, hi);
    send_sync(40, hi);
    send_sync(40, hi);
    check(locked, "R9 single outlier keeps lock", locked, 1);
    // R10 two outliers
    send_sync(60, hi);
    send_sync(60, hi);
    send_sync(60, hi);
    check(!locked, "R10 lock dropped", locked, 0);
    check(hi == 0, "R10 output blanked", hi, 0);
    repeat (3) send_sync(60, hi);
    check(!locked, "R8 relock pending", locked, 0);
    send_sync(60, hi);
    check(locked, "R8 relocked", locked, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule